// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Set/Clear Register Aliases

This block gathers up to sixteen level-sensitive interrupt lines from board peripherals and presents one combined, registered interrupt line to a host processor. The host reaches the block over a simple register bus with 16-bit data. Each register occupies the low half of a 32-bit slot, so consecutive registers are 4 bytes apart. For every source the block keeps three bits. A capture-enable bit decides whether an active level is latched into the pending status. A pending bit records the latched event. An output-mask bit decides whether that pending event can drive the host line.

The enable and mask vectors are never written directly. Each has one address where ones in the data set bits and another address where ones in the data clear bits. Zero data bits leave bits unchanged, so a single source can be switched without a read-modify-write. Pending bits are acknowledged by writing ones to the status address. A source whose level is still present and whose capture is enabled latches again. Two plain read/write registers, a scratch word and a control word, complete the map. Source inputs are resynchronised with two flops before capture.

Top module: `irq_agg_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), enable, mask, pending, scratch and control registers are cleared and `host_irq` is 0 after that edge.
- R2: The scratch word at byte offset 0x00 and the control word at byte offset 0x04 store all 16 bits of a write. A read strobe returns the addressed value on `bus_rdata` one cycle later. `bus_rdata` is 0 in any cycle that does not follow a read strobe.
- R3: A write to byte offset 0x0C sets every enable bit whose data bit is 1 and leaves the others unchanged. Reading offset 0x0C or 0x10 returns the enable vector.
- R4: A write to byte offset 0x10 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R5: A write to byte offset 0x14 sets mask bits, and a write to byte offset 0x18 clears mask bits, both under the same ones-only rule. Reading either offset returns the mask vector.
- R6: A source whose input is high and whose enable bit is 1 sets its pending bit, which is read at byte offset 0x08 (bit i = source i). The pending bit is set 3 clock edges after the input rises: two synchroniser stages plus the capture flop. A source with its enable bit at 0 never becomes pending.
- R7: Writing ones to byte offset 0x08 clears those pending bits. If the source is still high and enabled in the same cycle, the new capture wins and the bit stays set.
- R8: `host_irq` is a register that goes high one edge after some source has both its pending and mask bits set, and goes low one edge after no such source remains.
- R9: Reads of unmapped word offsets (byte offset 0x1C and above) return 0. Writes to them change no register.
- R10: After ones are written to enable-clear, mask-clear and status, `host_irq` stays low even while every source input is held high. Clearing only the mask, or only the enable followed by an acknowledge, also leaves `host_irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits [1:0] are ignored |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe; data is returned one cycle later |
| bus_rdata | output | 16 | Read data, registered |
| src_in | input | 16 | Level-sensitive interrupt sources, asynchronous |
| host_irq | output | 1 | Combined registered interrupt to the host |

## Verification
An acknowledge write to the status address and a fresh capture from a source that is still high and enabled can land on the same clock edge. The bench provokes this by holding a source high with capture enabled while it writes the acknowledge. It then reads the status back and expects the bit to remain set. After the source is dropped and the synchroniser has drained, a second acknowledge must clear the bit. A set write and a clear write to the same vector cannot collide, because each sits at its own address and only one write strobe is allowed per cycle.

// File: rtl/irq_agg_pkg.sv
// Package: shared register indices for the interrupt aggregator.
// Assumes one 16-bit register per 32-bit slot, so the word index is addr[4:2].
package irq_agg_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_SCRATCH = 3'd0,
        IDX_CTRL    = 3'd1,
        IDX_STATUS  = 3'd2,
        IDX_EN_SET  = 3'd3,
        IDX_EN_CLR  = 3'd4,
        IDX_MSK_SET = 3'd5,
        IDX_MSK_CLR = 3'd6
    } reg_idx_e;

    localparam int NUM_MAPPED = 7;

endpackage

// File: rtl/irq_agg_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous levels.
// Assumes each bit is an independent slow level, so no bus coherence is needed.
module irq_agg_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/irq_agg_bus.sv
// Module: bus decode, scratch/control storage and registered read mux.
// Assumes at most one strobe per cycle and that the address is a byte address.
module irq_agg_bus
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] mask_vec,
    input  logic [NUM_SRC-1:0] pend_vec,
    output logic               we_status,
    output logic               we_en_set,
    output logic               we_en_clr,
    output logic               we_msk_set,
    output logic               we_msk_clr
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_sel;
    logic              mapped;
    reg_idx_e          idx;
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_mux;

    assign word_sel = bus_addr[ADDR_W-1:2];
    assign mapped   = (word_sel < WORD_W'(NUM_MAPPED));
    assign idx      = reg_idx_e'(word_sel[IDX_W-1:0]);

    // Decode write strobes for the per-source vectors.
    always_comb begin
        we_status  = bus_wr && mapped && (idx == IDX_STATUS);
        we_en_set  = bus_wr && mapped && (idx == IDX_EN_SET);
        we_en_clr  = bus_wr && mapped && (idx == IDX_EN_CLR);
        we_msk_set = bus_wr && mapped && (idx == IDX_MSK_SET);
        we_msk_clr = bus_wr && mapped && (idx == IDX_MSK_CLR);
    end

    // Hold the two plain read/write words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            ctrl_q    <= '0;
        end else if (bus_wr && mapped) begin
            if (idx == IDX_SCRATCH) scratch_q <= bus_wdata;
            if (idx == IDX_CTRL)    ctrl_q    <= bus_wdata;
        end
    end

    // Select the addressed register; unmapped words read as zero.
    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            unique case (idx)
                IDX_SCRATCH:             rd_mux = scratch_q;
                IDX_CTRL:                rd_mux = ctrl_q;
                IDX_STATUS:              rd_mux = DATA_W'(pend_vec);
                IDX_EN_SET, IDX_EN_CLR:   rd_mux = DATA_W'(en_vec);
                IDX_MSK_SET, IDX_MSK_CLR: rd_mux = DATA_W'(mask_vec);
                default:                 rd_mux = '0;
            endcase
        end
    end

    // Register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/irq_agg_core.sv
// Module: per-source enable, mask and pending state plus the combined output.
// Assumes synchronised source levels and one-hot write strobes from the decoder.
module irq_agg_core #(
    parameter int NUM_SRC = 16,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_sync,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               we_status,
    input  logic               we_en_set,
    input  logic               we_en_clr,
    input  logic               we_msk_set,
    input  logic               we_msk_clr,
    output logic [NUM_SRC-1:0] en_vec,
    output logic [NUM_SRC-1:0] mask_vec,
    output logic [NUM_SRC-1:0] pend_vec,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] bits;
    logic [NUM_SRC-1:0] hit;

    assign bits = wdata[NUM_SRC-1:0];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Update one source's enable bit from the set/clear aliases.
        always_ff @(posedge clk) begin
            if (!rst_n)                     en_vec[i] <= 1'b0;
            else if (we_en_set && bits[i])  en_vec[i] <= 1'b1;
            else if (we_en_clr && bits[i])  en_vec[i] <= 1'b0;
        end

        // Update one source's mask bit from the set/clear aliases.
        always_ff @(posedge clk) begin
            if (!rst_n)                      mask_vec[i] <= 1'b0;
            else if (we_msk_set && bits[i])  mask_vec[i] <= 1'b1;
            else if (we_msk_clr && bits[i])  mask_vec[i] <= 1'b0;
        end

        // Capture an enabled level; capture beats a same-cycle acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                          pend_vec[i] <= 1'b0;
            else if (src_sync[i] && en_vec[i])   pend_vec[i] <= 1'b1;
            else if (we_status && bits[i])       pend_vec[i] <= 1'b0;
        end

        assign hit[i] = pend_vec[i] & mask_vec[i];
    end

    // Register the combined host interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |hit;
    end

endmodule

// File: rtl/irq_agg_regs.sv
// Module: top of the interrupt aggregator; wires synchroniser, decoder and core.
// Assumes NUM_SRC <= DATA_W and ADDR_W >= 5.
module irq_agg_regs #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               host_irq
);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic we_status, we_en_set, we_en_clr, we_msk_set, we_msk_clr;

    irq_agg_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (src_sync)
    );

    irq_agg_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .en_vec     (en_vec),
        .mask_vec   (mask_vec),
        .pend_vec   (pend_vec),
        .we_status  (we_status),
        .we_en_set  (we_en_set),
        .we_en_clr  (we_en_clr),
        .we_msk_set (we_msk_set),
        .we_msk_clr (we_msk_clr)
    );

    irq_agg_core #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sync   (src_sync),
        .wdata      (bus_wdata),
        .we_status  (we_status),
        .we_en_set  (we_en_set),
        .we_en_clr  (we_en_clr),
        .we_msk_set (we_msk_set),
        .we_msk_clr (we_msk_clr),
        .en_vec     (en_vec),
        .mask_vec   (mask_vec),
        .pend_vec   (pend_vec),
        .irq_out    (host_irq)
    );

endmodule

// File: rtl/irq_agg_regs_chk.sv
// Module: property checker for the aggregator, bound to the top module.
// Assumes the default byte map; decodes writes from the bus ports on its own.
module irq_agg_regs_chk #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               host_irq,
    input logic [NUM_SRC-1:0] src_sync,
    input logic [NUM_SRC-1:0] en_vec,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic [NUM_SRC-1:0] pend_vec
);

    logic [ADDR_W-3:0]  w;
    logic [NUM_SRC-1:0] d;
    assign w = bus_addr[ADDR_W-1:2];
    assign d = bus_wdata[NUM_SRC-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!host_irq && pend_vec == '0 && en_vec == '0)); // R1

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == (ADDR_W-2)'(3)) |=> ((en_vec & $past(d)) == $past(d))); // R3

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == (ADDR_W-2)'(4)) |=> ((en_vec & $past(d)) == '0)); // R4

    AST_MSK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == (ADDR_W-2)'(6)) |=> ((mask_vec & $past(d)) == '0)); // R5

    AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(en_vec)) == '0)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && w == (ADDR_W-2)'(2))
        |=> ((pend_vec & $past(d & ~(src_sync & en_vec))) == '0)); // R7

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(mask_vec != '0)); // R8

endmodule

bind irq_agg_regs irq_agg_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .host_irq  (host_irq),
    .src_sync  (src_sync),
    .en_vec    (en_vec),
    .mask_vec  (mask_vec),
    .pend_vec  (pend_vec)
);

// File: tb/irq_agg_regs_test.sv
module irq_agg_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] src_in = '0;
    logic        host_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    logic  rd_seen = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_agg_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_in(src_in), .host_irq(host_irq)
    );

    // Driver side: register writes and scoreboarded reads.
    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_tests++;
        if (host_irq !== e) begin
            n_fail++;
            $display("FAIL %s host_irq actual=%0b expected=%0b", tag, host_irq, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor side: note read strobes, then compare returned data.
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            item_t it;
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end else if (!done && rst_n && bus_rdata !== 16'h0) begin
            n_tests++; n_fail++;
            $display("FAIL R2 idle rdata actual=%h expected=0000", bus_rdata);
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        chk_irq(1'b0, "R1 irq after reset");
        rst_n = 1'b1;
        rd(5'h08, 16'h0000, "R1 status");
        rd(5'h0C, 16'h0000, "R1 enable");
        rd(5'h14, 16'h0000, "R1 mask");
        rd(5'h00, 16'h0000, "R1 scratch");

        // R2: scratch and control
        wr(5'h00, 16'hA5C3);
        wr(5'h04, 16'h1E0F);
        rd(5'h00, 16'hA5C3, "R2 scratch");
        rd(5'h05, 16'h1E0F, "R2 control low bits ignored");

        // R3/R4: enable set and clear aliases
        wr(5'h0C, 16'h00F0);
        wr(5'h0C, 16'h0300);
        rd(5'h10, 16'h03F0, "R3 enable set readback");
        wr(5'h10, 16'h0110);
        rd(5'h0C, 16'h02E0, "R4 enable clear");

        // R5: mask set and clear aliases
        wr(5'h14, 16'hFF00);
        wr(5'h18, 16'h0F00);
        rd(5'h18, 16'hF000, "R5 mask");
        wr(5'h18, 16'hFFFF);
        wr(5'h10, 16'hFFFF);

        // R9: unmapped offset
        wr(5'h1C, 16'hFFFF);
        rd(5'h1C, 16'h0000, "R9 unmapped read");
        rd(5'h00, 16'hA5C3, "R9 scratch untouched");
        rd(5'h0C, 16'h0000, "R9 enable untouched");

        // R6: capture only when enabled
        wr(5'h0C, 16'h0001);
        src_in = 16'h0003;
        idle(5);
        rd(5'h08, 16'h0001, "R6 capture enabled only");
        chk_irq(1'b0, "R8 no mask no irq");

        // R8: mask raises output
        wr(5'h14, 16'h0001);
        idle(1);
        chk_irq(1'b1, "R8 irq asserted");

        // R7: ack while still high -> capture wins
        wr(5'h08, 16'h0001);
        rd(5'h08, 16'h0001, "R7 re-pend after ack");
        src_in = 16'h0000;
        idle(4);
        wr(5'h08, 16'h0001);
        rd(5'h08, 16'h0000, "R7 ack clears");
        chk_irq(1'b0, "R8 irq drops");

        // R10: mask-only clear silences output, pending stays
        wr(5'h0C, 16'h0004);
        wr(5'h14, 16'h0004);
        src_in = 16'h0004;
        idle(5);
        chk_irq(1'b1, "R10 irq before mask clear");
        wr(5'h18, 16'h0004);
        idle(1);
        chk_irq(1'b0, "R10 mask clear only");
        rd(5'h08, 16'h0004, "R10 pending kept");

        // R10: enable-only clear plus ack, mask still set
        wr(5'h14, 16'h0004);
        wr(5'h10, 16'h0004);
        wr(5'h08, 16'h0004);
        idle(2);
        chk_irq(1'b0, "R10 enable clear and ack");
        rd(5'h08, 16'h0000, "R10 no recapture");

        // R10: full shutdown with all sources high
        wr(5'h0C, 16'hFFFF);
        wr(5'h14, 16'hFFFF);
        src_in = 16'hFFFF;
        idle(5);
        chk_irq(1'b1, "R10 all sources irq");
        wr(5'h10, 16'hFFFF);
        wr(5'h18, 16'hFFFF);
        wr(5'h08, 16'hFFFF);
        idle(6);
        chk_irq(1'b0, "R10 full shutdown");
        rd(5'h08, 16'h0000, "R10 status empty");

        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule